// File: doc/BRIEF.md
# Virtual-Function Aperture Base Register Array

This block holds the six base-address dwords that a physical function exposes for the apertures of its virtual functions. Each slot is fixed at elaboration with a type code (I/O, 32-bit memory or 64-bit memory, with a prefetch flag) and a power-of-two aperture size. Configuration reads and writes reach the slots through a dword address with byte enables. A write mask is derived from the aperture size. Software sizes an aperture by writing all ones and reading back the mask, then programs a base address.

A 64-bit memory slot joins with the dword above it. That upper dword is the upper half of the region and ignores its own type and size settings. For every slot the block outputs the programmed 64-bit base, with the type bits removed, and a flag that is high while that base is non-zero. Reset returns every dword to its type code, which clears all programmed bases. An illegal size fails at elaboration.

Top module: `vfbar_array`

## Requirements
- R1: After reset, each lower or 32-bit slot reads back its type code, each upper-half slot reads zero, and every base output and valid flag is zero.
- R2: Slot r answers at byte address CAP_BASE + BAR_OFF + 4·r for r = 0..5. A read elsewhere returns rd_hit = 0 and rdata = 0. A write elsewhere changes no slot.
- R3: A writable bit is a set bit of ~(size − 1). Writing all ones reads back that mask OR the type code, and every base output is a multiple of its size.
- R4: The type bits cannot be written. For memory these are bits [3:0]: bit 0 = 0, bits [2:1] = 00 for 32-bit or 10 for 64-bit, bit 3 = prefetchable.
- R5: A 64-bit memory slot takes its lower 32 mask bits from ~(size − 1)[31:0] and its upper dword's mask from ~(size − 1)[63:32]. Its base output is {upper dword, lower dword with type bits cleared}. The upper slot's own base and valid outputs stay zero.
- R6: Only bytes with their enable set are updated, and outputs change only after a write.
- R7: rdata and rd_hit are registered. They show the addressed dword one cycle after rd_en and are zero otherwise.
- R8: A slot's valid flag is high exactly when its base output is non-zero.
- R9: For I/O slots (type bit 0 = 1) only bits [1:0] are fixed, with reset value 01.
- R10: A size that is zero, not a power of two, below 16 for memory or 4 for I/O, or above 2^31 for a non-64-bit slot fails elaboration. So does a 64-bit slot placed in the last position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Configuration byte address (bits [1:0] ignored) |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after rd_en |
| cfg_rd_hit | output | 1 | Read hit a slot, one cycle after rd_en |
| region_base | output | 6×64 | Programmed base per slot, type bits cleared |
| region_valid | output | 6 | Base is non-zero, per slot |

## Verification
A read returns its data on the edge after rd_en. The bench raises rd_en on a falling edge and samples rdata and rd_hit on the next falling edge, which falls exactly one register stage later. A write reaches the slot register, and through combinational logic the base and valid outputs, on the edge it is presented at. Base and valid checks are therefore sampled on the falling edge that follows the write. After reset is released the bench waits more than the two synchronizer stages before it issues any access.

// File: rtl/vfbar_pkg.sv
package vfbar_pkg;

  localparam int NUM_SLOTS = 6;

  typedef enum logic [1:0] {
    ROLE_LO32 = 2'd0,
    ROLE_LO64 = 2'd1,
    ROLE_HI64 = 2'd2
  } role_e;

  function automatic logic type_is_io(input logic [3:0] t);
    return t[0];
  endfunction

  function automatic logic type_is_mem64(input logic [3:0] t);
    return (t[0] == 1'b0) && (t[2:1] == 2'b10);
  endfunction

  // Walk the slots from the bottom: the dword above a 64-bit slot is its upper half.
  function automatic role_e slot_role(input logic [NUM_SLOTS-1:0][3:0] types, input int s);
    role_e cur;
    role_e prev;
    cur  = ROLE_LO32;
    prev = ROLE_LO32;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (i <= s) begin
        if (i > 0 && prev == ROLE_LO64) cur = ROLE_HI64;
        else if (type_is_mem64(types[i])) cur = ROLE_LO64;
        else cur = ROLE_LO32;
        prev = cur;
      end
    end
    return cur;
  endfunction

  function automatic logic [31:0] fixed_bits(input logic [3:0] t);
    return type_is_io(t) ? 32'h0000_0003 : 32'h0000_000F;
  endfunction

  function automatic logic [31:0] slot_mask(input logic [NUM_SLOTS-1:0][3:0] types,
                                            input logic [NUM_SLOTS-1:0][63:0] sizes,
                                            input int s);
    logic [63:0] full;
    role_e r;
    r = slot_role(types, s);
    if (r == ROLE_HI64) begin
      full = (s > 0) ? ~(sizes[s-1] - 64'd1) : 64'd0;
      return full[63:32];
    end
    full = ~(sizes[s] - 64'd1);
    return full[31:0] & ~fixed_bits(types[s]);
  endfunction

  function automatic logic [31:0] slot_reset(input logic [NUM_SLOTS-1:0][3:0] types, input int s);
    if (slot_role(types, s) == ROLE_HI64) return 32'd0;
    return {28'd0, types[s]} & fixed_bits(types[s]);
  endfunction

endpackage

// File: rtl/vfbar_rst_sync.sv
module vfbar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/vfbar_decode.sv
module vfbar_decode #(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CAP_BASE = 12'h160,
  parameter logic [ADDR_W-1:0] BAR_OFF  = 12'h024
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [2:0]        idx
);
  import vfbar_pkg::*;

  localparam logic [ADDR_W-1:0] START = CAP_BASE + BAR_OFF;

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-3:0] dw;
  logic              unused_lo;

  always_comb begin
    rel       = addr - START;
    dw        = rel[ADDR_W-1:2];
    unused_lo = ^rel[1:0];
    hit       = (addr >= START) && (32'(dw) < NUM_SLOTS);
    idx       = rel[4:2];
  end
endmodule

// File: rtl/vfbar_dword.sv
module vfbar_dword #(
  parameter logic [31:0] WMASK   = 32'h0,
  parameter logic [31:0] RST_VAL = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  logic [31:0] q_d;

  always_comb begin
    q_d = q;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) q_d[8*b +: 8] = (wdata[8*b +: 8] & WMASK[8*b +: 8]) |
                                 (q[8*b +: 8] & ~WMASK[8*b +: 8]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= q_d;
  end
endmodule

// File: rtl/vfbar_rdport.sv
module vfbar_rdport (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  rd_en,
  input  logic                                  hit,
  input  logic [2:0]                            idx,
  input  logic [vfbar_pkg::NUM_SLOTS-1:0][31:0] words,
  output logic [31:0]                           rdata,
  output logic                                  rd_hit
);
  logic [31:0] rdata_d;
  logic        hit_d;

  always_comb begin
    hit_d   = rd_en && hit;
    rdata_d = 32'd0;
    if (hit_d) rdata_d = words[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= 32'd0;
      rd_hit <= 1'b0;
    end else begin
      rdata  <= rdata_d;
      rd_hit <= hit_d;
    end
  end
endmodule

// File: rtl/vfbar_array.sv
module vfbar_array #(
  parameter int                                   ADDR_W      = 12,
  parameter logic [ADDR_W-1:0]                    CAP_BASE    = 12'h160,
  parameter logic [ADDR_W-1:0]                    BAR_OFF     = 12'h024,
  parameter logic [vfbar_pkg::NUM_SLOTS-1:0][3:0] REGION_TYPE =
    {4'h0, 4'h4, 4'h0, 4'hC, 4'h1, 4'h0},
  parameter logic [vfbar_pkg::NUM_SLOTS-1:0][63:0] REGION_SIZE =
    {64'h0, 64'h2_0000_0000, 64'h0, 64'h10_0000, 64'h100, 64'h1000}
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    cfg_wr_en,
  input  logic                                    cfg_rd_en,
  input  logic [ADDR_W-1:0]                       cfg_addr,
  input  logic [3:0]                              cfg_be,
  input  logic [31:0]                             cfg_wdata,
  output logic [31:0]                             cfg_rdata,
  output logic                                    cfg_rd_hit,
  output logic [vfbar_pkg::NUM_SLOTS-1:0][63:0]   region_base,
  output logic [vfbar_pkg::NUM_SLOTS-1:0]         region_valid
);
  import vfbar_pkg::*;

  logic                        rst_int_n;
  logic                        hit;
  logic [2:0]                  idx;
  logic [NUM_SLOTS-1:0][31:0]  words;

  vfbar_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  vfbar_decode #(.ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE), .BAR_OFF(BAR_OFF)) u_dec (
    .addr(cfg_addr), .hit(hit), .idx(idx)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam role_e       ROLE = slot_role(REGION_TYPE, s);
    localparam logic [31:0] MASK = slot_mask(REGION_TYPE, REGION_SIZE, s);
    localparam logic [31:0] RSTV = slot_reset(REGION_TYPE, s);
    localparam logic [63:0] SZ   = REGION_SIZE[s];

    // R10: elaboration-time legality of each configured aperture
    if (ROLE != ROLE_HI64) begin : g_chk
      if (SZ == 64'd0 || (SZ & (SZ - 64'd1)) != 64'd0) begin : g_pow2
        $error("vfbar_array: slot %0d size is not a power of two", s);
      end
      if (type_is_io(REGION_TYPE[s]) && SZ < 64'd4) begin : g_iomin
        $error("vfbar_array: slot %0d I/O size below 4", s);
      end
      if (!type_is_io(REGION_TYPE[s]) && SZ < 64'd16) begin : g_memmin
        $error("vfbar_array: slot %0d memory size below 16", s);
      end
      if (ROLE == ROLE_LO32 && SZ > 64'h8000_0000) begin : g_max32
        $error("vfbar_array: slot %0d size exceeds 32-bit aperture", s);
      end
      if (ROLE == ROLE_LO64 && s == NUM_SLOTS - 1) begin : g_top64
        $error("vfbar_array: 64-bit slot %0d has no upper dword", s);
      end
    end

    logic slot_wr;
    assign slot_wr = cfg_wr_en && hit && (idx == 3'(s));

    vfbar_dword #(.WMASK(MASK), .RST_VAL(RSTV)) u_dw (
      .clk(clk), .rst_n(rst_int_n), .wr_en(slot_wr),
      .be(cfg_be), .wdata(cfg_wdata), .q(words[s])
    );

    // R5/R8: base assembly per role, valid when non-zero
    if (ROLE == ROLE_LO64) begin : g_b64
      assign region_base[s] = {words[s+1], words[s] & ~fixed_bits(REGION_TYPE[s])};
    end else if (ROLE == ROLE_LO32) begin : g_b32
      assign region_base[s] = {32'd0, words[s] & ~fixed_bits(REGION_TYPE[s])};
    end else begin : g_bhi
      assign region_base[s] = 64'd0;
    end
    assign region_valid[s] = |region_base[s];
  end

  vfbar_rdport u_rd (
    .clk(clk), .rst_n(rst_int_n), .rd_en(cfg_rd_en), .hit(hit), .idx(idx),
    .words(words), .rdata(cfg_rdata), .rd_hit(cfg_rd_hit)
  );
endmodule

// File: rtl/vfbar_array_chk.sv
module vfbar_array_chk #(
  parameter logic [vfbar_pkg::NUM_SLOTS-1:0][3:0]  REGION_TYPE = '0,
  parameter logic [vfbar_pkg::NUM_SLOTS-1:0][63:0] REGION_SIZE = '0
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  cfg_wr_en,
  input logic                                  cfg_rd_en,
  input logic [31:0]                           cfg_rdata,
  input logic                                  cfg_rd_hit,
  input logic [vfbar_pkg::NUM_SLOTS-1:0][63:0] region_base,
  input logic [vfbar_pkg::NUM_SLOTS-1:0]       region_valid
);
  import vfbar_pkg::*;

  p_hit_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_hit |-> $past(cfg_rd_en));

  p_idle_rdata_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd_hit |-> (cfg_rdata == 32'd0));

  p_base_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(region_base));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_p
    p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(region_valid[s]) |-> $past(cfg_wr_en));
    if (slot_role(REGION_TYPE, s) != ROLE_HI64) begin : g_al
      p_base_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (region_base[s] & (REGION_SIZE[s] - 64'd1)) == 64'd0);
    end
  end
endmodule

bind vfbar_array vfbar_array_chk #(.REGION_TYPE(REGION_TYPE), .REGION_SIZE(REGION_SIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
  .cfg_rdata(cfg_rdata), .cfg_rd_hit(cfg_rd_hit),
  .region_base(region_base), .region_valid(region_valid)
);

// File: tb/vfbar_array_bench.sv
module vfbar_array_bench;
  logic              clk;
  logic              rst_n;
  logic              cfg_wr_en;
  logic              cfg_rd_en;
  logic [11:0]       cfg_addr;
  logic [3:0]        cfg_be;
  logic [31:0]       cfg_wdata;
  logic [31:0]       cfg_rdata;
  logic              cfg_rd_hit;
  logic [5:0][63:0]  region_base;
  logic [5:0]        region_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  vfbar_array u_vfbar_array (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rd_hit(cfg_rd_hit),
    .region_base(region_base), .region_valid(region_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] data;  // write data, or expected read data
    logic [15:0] tag;
  } vec_t;

  // slots at 0x184 + 4r; types 0,1,C,(hi),4,(hi); sizes 4K,256,1M,-,8G,-
  localparam vec_t VECS [18] = '{
    '{1'b0, 12'h184, 4'hF, 32'h0000_0000, "R1"},
    '{1'b0, 12'h188, 4'hF, 32'h0000_0001, "R9"},
    '{1'b0, 12'h18C, 4'hF, 32'h0000_000C, "R4"},
    '{1'b0, 12'h190, 4'hF, 32'h0000_0000, "R1"},
    '{1'b0, 12'h194, 4'hF, 32'h0000_0004, "R4"},
    '{1'b0, 12'h198, 4'hF, 32'h0000_0000, "R1"},
    '{1'b1, 12'h184, 4'hF, 32'hFFFF_FFFF, "R3"},
    '{1'b1, 12'h188, 4'hF, 32'hFFFF_FFFF, "R3"},
    '{1'b1, 12'h18C, 4'hF, 32'hFFFF_FFFF, "R3"},
    '{1'b1, 12'h190, 4'hF, 32'hFFFF_FFFF, "R5"},
    '{1'b1, 12'h194, 4'hF, 32'hFFFF_FFFF, "R5"},
    '{1'b1, 12'h198, 4'hF, 32'hFFFF_FFFF, "R5"},
    '{1'b0, 12'h184, 4'hF, 32'hFFFF_F000, "R3"},
    '{1'b0, 12'h188, 4'hF, 32'hFFFF_FF01, "R9"},
    '{1'b0, 12'h18C, 4'hF, 32'hFFF0_000C, "R4"},
    '{1'b0, 12'h190, 4'hF, 32'hFFFF_FFFF, "R5"},
    '{1'b0, 12'h194, 4'hF, 32'h0000_0004, "R5"},
    '{1'b0, 12'h198, 4'hF, 32'hFFFF_FFFE, "R5"}
  };

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic hitv, output logic [31:0] d);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    hitv = cfg_rd_hit;
    d    = cfg_rdata;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic        h;
    logic [31:0] d;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_rd_en = 1'b0;
    cfg_addr = '0; cfg_be = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset outputs
    check64("R1 base0", region_base[0], 64'h0);
    check64("R1 base4", region_base[4], 64'h0);
    check64("R1 valid", {58'd0, region_valid}, 64'h0);

    for (int i = 0; i < 18; i++) begin
      if (VECS[i].wr) begin
        do_write(VECS[i].addr, VECS[i].be, VECS[i].data);
      end else begin
        do_read(VECS[i].addr, h, d);
        check64({VECS[i].tag, " hit"}, {63'd0, h}, 64'd1);
        check64({VECS[i].tag, " read"}, {32'd0, d}, {32'd0, VECS[i].data});
      end
    end

    // R3/R5: base outputs after sizing writes
    check64("R3 base0", region_base[0], 64'h0000_0000_FFFF_F000);
    check64("R9 base1", region_base[1], 64'h0000_0000_FFFF_FF00);
    check64("R5 base2", region_base[2], 64'hFFFF_FFFF_FFF0_0000);
    check64("R5 base4", region_base[4], 64'hFFFF_FFFE_0000_0000);
    check64("R5 base3", region_base[3], 64'h0);
    check64("R8 valid", {58'd0, region_valid}, {58'd0, 6'b010111});

    // R6: byte enable on byte 1 only
    do_write(12'h184, 4'b0010, 32'h0000_5A00);
    do_read(12'h184, h, d);
    check64("R6 byte", {32'd0, d}, 64'hFFFF_5000);

    // R2: outside reads and writes
    do_read(12'h180, h, d);
    check64("R2 miss hit", {63'd0, h}, 64'd0);
    check64("R2 miss data", {32'd0, d}, 64'd0);
    do_write(12'h19C, 4'hF, 32'h0);
    do_write(12'h180, 4'hF, 32'h0);
    do_read(12'h198, h, d);
    check64("R2 no effect hi", {32'd0, d}, 64'hFFFF_FFFE);
    do_read(12'h184, h, d);
    check64("R2 no effect lo", {32'd0, d}, 64'hFFFF_5000);

    // R8: clearing a base drops its valid
    do_write(12'h188, 4'hF, 32'h0);
    check64("R8 valid1 low", {63'd0, region_valid[1]}, 64'd0);
    check64("R8 base1", region_base[1], 64'h0);

    // R5: only the upper dword set keeps a 64-bit region valid
    do_write(12'h194, 4'hF, 32'h0);
    check64("R5 base4 upper only", region_base[4], 64'hFFFF_FFFE_0000_0000);
    do_write(12'h198, 4'hF, 32'h0000_0002);
    check64("R5 base4 8G", region_base[4], 64'h0000_0002_0000_0000);

    // R7: no read strobe means no hit
    @(negedge clk);
    check64("R7 idle", {31'd0, cfg_rd_hit, cfg_rdata}, 64'h0);

    // R1: reset mid-run restores types
    apply_reset();
    check64("R1 valid after reset", {58'd0, region_valid}, 64'h0);
    do_read(12'h18C, h, d);
    check64("R1 type2", {32'd0, d}, 64'h0000_000C);
    do_read(12'h198, h, d);
    check64("R1 hi5", {32'd0, d}, 64'h0);

    finish_run();
  end
endmodule